// File: doc/BRIEF.md
# Instruction Decode and In-Order Issue Queue

This block takes 32-bit instruction words, each tagged with an instruction number that grows with program order, over a valid/ready handshake. It splits every word into its format, operation code, destination, source registers and immediate, and holds the result in a small ordered queue. The queue releases up to `IW` instructions per cycle, always starting with the oldest. Each released instruction goes to its own execution port as a decoded bundle.

Readiness comes from a 16-register scoreboard that counts the pending writers of each register. When an instruction enters the queue, it records how many older writers each of its source registers still waits on. Each writeback broadcast on the `wb_*` ports counts one of them down. An instruction becomes eligible in the cycle after its last awaited writeback. A blocked oldest entry holds back every younger one. Register data, the arithmetic and the meaning of the jump and prompt formats belong to other blocks.

Top module: `decode_issue_queue`

## Requirements
- R1: A clock edge with `rst_n` low empties the queue and clears every pending writer. Afterwards `in_ready` is 1, `iss_valid` is 0, and a newly queued reader of any register can issue.
- R2: When bits [31:30] are 00 (R format), the bundle reports `fmt`=0, the operation from bits [29:26], the destination from [25:21], source one from [20:16] and source two from [15:11]. Bits [10:0] are dropped, and the reported immediate is 0.
- R3: When bits [31:30] are 01 (I format), the bundle reports `fmt`=1, the operation, the destination and source one from the same positions as R2, source two as 0, and the immediate from bits [15:0]. Only source one is checked for readiness, so bits [15:11] naming a pending register cause no delay.
- R4: Formats 10 and 11 are passed through with the same field slicing and the immediate from [15:0]. They wait on no register and reserve no destination, so a later reader of their destination field is not delayed.
- R5: A reader of a register with an older, unfinished R-format or I-format writer waits. It issues no earlier than the cycle after the writeback broadcast for that register, and not during that broadcast. Registers are selected by field bits [3:0]; bit 4 is ignored.
- R6: If the oldest entry is not ready, nothing issues that cycle, even when younger entries are ready.
- R7: Each cycle, the longest run of ready entries counted from the oldest issues, capped at `IW`. Port 0 carries the oldest, and `iss_valid` is always a contiguous run of ones starting at port 0.
- R8: An instruction never issues in the same cycle as an older instruction that writes one of its source registers.
- R9: A reader waits for one writeback for each older pending writer of that register. Two broadcasts to the same register in one cycle count as two.
- R10: A younger writer to a register never delays an older reader of that register.
- R11: `in_ready` is 0 exactly when the queue holds `DEPTH` entries, and `q_full` is then 1. A word offered while `in_ready` is 0 is not accepted and never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction word is offered |
| in_ready | output | 1 | The queue accepts the offered word this cycle |
| in_word | input | 32 | Instruction word |
| in_id | input | ID_W | Program-order number of the word |
| q_full | output | 1 | The queue holds DEPTH entries |
| wb_valid | input | WB_N | One bit per writeback broadcast lane |
| wb_reg | input | WB_N*4 | Register written by each lane, 4 bits per lane |
| iss_valid | output | IW | Issue port carries an instruction |
| iss_id | output | IW*ID_W | Program-order number per issue port |
| iss_fmt | output | IW*2 | Format code per port |
| iss_op | output | IW*4 | Operation code per port |
| iss_dst | output | IW*5 | Destination field per port |
| iss_src1 | output | IW*5 | Source one field per port |
| iss_src2 | output | IW*5 | Source two field per port (0 unless R format) |
| iss_imm | output | IW*16 | Immediate per port (0 for R format) |

## Verification
The bench sweeps every register as a dependency target, in both source positions and with bit 4 of the field both set and clear. If the readiness were sampled combinationally from the broadcast, the reader would issue during the writeback cycle rather than the cycle after. It also builds a blocked head followed by ready younger entries; a design that let ready entries go past the head would show nonzero `iss_valid` there. Other cases stack two writers to one register, and pair an older reader with a younger writer. Miscounting writers would release the reader too early. Using a single ready bit per register would deadlock the older reader behind the younger writer. A word offered while the queue is full must never reach an issue port.

// File: rtl/dq_pkg.sv
// Package dq_pkg
// Shared types and format helpers for the decode/issue queue.
// Assumes 32-bit words with the format code in bits [31:30].
package dq_pkg;

    localparam int NREG  = 16;
    localparam int REG_W = 4;

    typedef enum logic [1:0] {
        FMT_REG  = 2'b00,
        FMT_IMM  = 2'b01,
        FMT_JMP  = 2'b10,
        FMT_PRM  = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e        fmt;
        logic [3:0]  op;
        logic [4:0]  dst;
        logic [4:0]  src1;
        logic [4:0]  src2;
        logic [15:0] imm;
    } dec_t;

    // Source one must be ready for register and immediate formats.
    function automatic logic uses_src1(input fmt_e f);
        return (f == FMT_REG) || (f == FMT_IMM);
    endfunction

    // Source two is a register only in the register format.
    function automatic logic uses_src2(input fmt_e f);
        return f == FMT_REG;
    endfunction

    // Register and immediate formats produce a register result.
    function automatic logic has_dest(input fmt_e f);
        return (f == FMT_REG) || (f == FMT_IMM);
    endfunction

endpackage

// File: rtl/dq_decode.sv
// Module dq_decode
// Purely combinational field extraction of one instruction word.
// Assumes formats 10 and 11 are only sliced, not interpreted.
module dq_decode
    import dq_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    // Slice the fields and zero the ones a format does not use.
    always_comb begin
        dec.fmt  = fmt_e'(word[31:30]);
        dec.op   = word[29:26];
        dec.dst  = word[25:21];
        dec.src1 = word[20:16];
        dec.src2 = (dec.fmt == FMT_REG) ? word[15:11] : 5'd0;
        dec.imm  = (dec.fmt == FMT_REG) ? 16'd0 : word[15:0];
    end

endmodule

// File: rtl/dq_scoreboard.sv
// Module dq_scoreboard
// Counts in-flight writers per architectural register.
// Assumes at most 2**PEND_W-1 writers of one register are in flight and
// that a writeback only names a register with a pending writer.
module dq_scoreboard
    import dq_pkg::*;
#(
    parameter int WB_N   = 2,
    parameter int PEND_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WB_N-1:0]              wb_valid,
    input  logic [WB_N*REG_W-1:0]        wb_reg,
    input  logic                         alloc_en,
    input  logic [REG_W-1:0]             alloc_reg,
    output logic [NREG-1:0][PEND_W-1:0]  pend,
    output logic [NREG-1:0][PEND_W-1:0]  hits
);

    // Count the broadcasts aimed at each register this cycle.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            hits[r] = '0;
            for (int p = 0; p < WB_N; p++) begin
                if (wb_valid[p] && (wb_reg[p*REG_W +: REG_W] == REG_W'(r)))
                    hits[r] = hits[r] + PEND_W'(1);
            end
        end
    end

    // Add the newly queued writer and retire the broadcast ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            for (int r = 0; r < NREG; r++)
                pend[r] <= pend[r] + PEND_W'(alloc_en && (alloc_reg == REG_W'(r))) - hits[r];
        end
    end

endmodule

// File: rtl/dq_queue.sv
// Module dq_queue
// Compacting in-order queue; entry 0 is always the oldest.
// Each entry keeps a count of older writers it still waits on per source.
// Assumes IW <= DEPTH and that push is only raised when not full.
module dq_queue
    import dq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IW     = 2,
    parameter int ID_W   = 8,
    parameter int PEND_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  dec_t                         push_dec,
    input  logic [ID_W-1:0]              push_id,
    input  logic [PEND_W-1:0]            push_w1,
    input  logic [PEND_W-1:0]            push_w2,
    input  logic [NREG-1:0][PEND_W-1:0]  hits,
    output logic                         full,
    output logic [IW-1:0]                iss_valid,
    output dec_t [IW-1:0]                iss_dec,
    output logic [IW-1:0][ID_W-1:0]      iss_id
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        dec_t              d;
        logic [ID_W-1:0]   id;
        logic [PEND_W-1:0] w1;
        logic [PEND_W-1:0] w2;
    } ent_t;

    ent_t             q     [DEPTH];
    ent_t             aged  [DEPTH];
    ent_t             q_nxt [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] n_iss;
    logic [DEPTH-1:0] ready;

    assign full = (cnt == CNT_W'(DEPTH));

    // An occupied entry is ready when every source it uses has no wait left.
    always_comb begin
        for (int j = 0; j < DEPTH; j++)
            ready[j] = (j < int'(cnt))
                    && (!uses_src1(q[j].d.fmt) || (q[j].w1 == '0))
                    && (!uses_src2(q[j].d.fmt) || (q[j].w2 == '0));
    end

    // Issue the leading run of ready entries, capped at IW.
    always_comb begin
        logic run;
        run   = 1'b1;
        n_iss = '0;
        for (int i = 0; i < IW; i++) begin
            run          = run && ready[i];
            iss_valid[i] = run;
            iss_dec[i]   = q[i].d;
            iss_id[i]    = q[i].id;
            n_iss        = n_iss + CNT_W'(run);
        end
    end

    // Count down waits, drop issued entries and append the new one.
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            aged[j] = q[j];
            aged[j].w1 = (q[j].w1 > hits[q[j].d.src1[REG_W-1:0]])
                       ? q[j].w1 - hits[q[j].d.src1[REG_W-1:0]] : '0;
            aged[j].w2 = (q[j].w2 > hits[q[j].d.src2[REG_W-1:0]])
                       ? q[j].w2 - hits[q[j].d.src2[REG_W-1:0]] : '0;
        end
        for (int j = 0; j < DEPTH; j++) begin
            q_nxt[j] = aged[j];
            if (j + int'(n_iss) < DEPTH)
                q_nxt[j] = aged[j + int'(n_iss)];
        end
        if (push)
            q_nxt[int'(cnt) - int'(n_iss)] = '{d: push_dec, id: push_id, w1: push_w1, w2: push_w2};
    end

    // Occupancy register with reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt - n_iss + CNT_W'(push);
    end

    // Entry storage; contents beyond the occupancy are don't-care.
    always_ff @(posedge clk) begin
        for (int j = 0; j < DEPTH; j++)
            q[j] <= q_nxt[j];
    end

endmodule

// File: rtl/decode_issue_queue.sv
// Module decode_issue_queue
// Top level: decodes incoming words, snapshots source waits from the
// scoreboard, and issues oldest-first through IW ports.
// Assumes writebacks only name registers with a pending writer.
module decode_issue_queue
    import dq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IW     = 2,
    parameter int WB_N   = 2,
    parameter int ID_W   = 8,
    parameter int PEND_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [31:0]           in_word,
    input  logic [ID_W-1:0]       in_id,
    output logic                  q_full,
    input  logic [WB_N-1:0]       wb_valid,
    input  logic [WB_N*4-1:0]     wb_reg,
    output logic [IW-1:0]         iss_valid,
    output logic [IW*ID_W-1:0]    iss_id,
    output logic [IW*2-1:0]       iss_fmt,
    output logic [IW*4-1:0]       iss_op,
    output logic [IW*5-1:0]       iss_dst,
    output logic [IW*5-1:0]       iss_src1,
    output logic [IW*5-1:0]       iss_src2,
    output logic [IW*16-1:0]      iss_imm
);

    dec_t                        in_dec;
    logic                        full_i;
    logic                        push;
    logic [NREG-1:0][PEND_W-1:0] pend;
    logic [NREG-1:0][PEND_W-1:0] hits;
    logic [PEND_W-1:0]           w1, w2;
    dec_t [IW-1:0]               iss_dec;
    logic [IW-1:0][ID_W-1:0]     iss_id_a;

    assign in_ready = !full_i;
    assign q_full   = full_i;
    assign push     = in_valid && !full_i;

    dq_decode u_decode (
        .word (in_word),
        .dec  (in_dec)
    );

    dq_scoreboard #(.WB_N(WB_N), .PEND_W(PEND_W)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .alloc_en  (push && has_dest(in_dec.fmt)),
        .alloc_reg (in_dec.dst[REG_W-1:0]),
        .pend      (pend),
        .hits      (hits)
    );

    // Older writers still outstanding after this cycle's broadcasts.
    always_comb begin
        w1 = uses_src1(in_dec.fmt)
           ? pend[in_dec.src1[REG_W-1:0]] - hits[in_dec.src1[REG_W-1:0]] : '0;
        w2 = uses_src2(in_dec.fmt)
           ? pend[in_dec.src2[REG_W-1:0]] - hits[in_dec.src2[REG_W-1:0]] : '0;
    end

    dq_queue #(.DEPTH(DEPTH), .IW(IW), .ID_W(ID_W), .PEND_W(PEND_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_dec  (in_dec),
        .push_id   (in_id),
        .push_w1   (w1),
        .push_w2   (w2),
        .hits      (hits),
        .full      (full_i),
        .iss_valid (iss_valid),
        .iss_dec   (iss_dec),
        .iss_id    (iss_id_a)
    );

    for (genvar i = 0; i < IW; i++) begin : g_port
        assign iss_id  [i*ID_W +: ID_W] = iss_id_a[i];
        assign iss_fmt [i*2    +: 2]    = iss_dec[i].fmt;
        assign iss_op  [i*4    +: 4]    = iss_dec[i].op;
        assign iss_dst [i*5    +: 5]    = iss_dec[i].dst;
        assign iss_src1[i*5    +: 5]    = iss_dec[i].src1;
        assign iss_src2[i*5    +: 5]    = iss_dec[i].src2;
        assign iss_imm [i*16   +: 16]   = iss_dec[i].imm;
    end

endmodule

// File: rtl/dq_checker.sv
// Module dq_checker
// Protocol and ordering properties of decode_issue_queue, bound to it.
// Assumes synchronous active-low reset.
module dq_checker #(
    parameter int IW   = 2,
    parameter int WB_N = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic [WB_N-1:0] wb_valid,
    input logic [IW-1:0]   iss_valid,
    input logic [IW*2-1:0] iss_fmt,
    input logic [IW*5-1:0] iss_dst,
    input logic [IW*5-1:0] iss_src1,
    input logic [IW*5-1:0] iss_src2
);

    logic unused_hi;
    assign unused_hi = ^{iss_dst, iss_src1, iss_src2};

    // Blocked head with no broadcast stays blocked while full (R6).
    assert_blocked_head_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid[0] && !in_ready && (wb_valid == '0)) |=> !iss_valid[0]);

    // A full queue that issues nothing stays full (R11).
    assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !iss_valid[0]) |=> !in_ready);

    for (genvar i = 1; i < IW; i++) begin : g_ord
        // Issue ports fill from port 0 with no gaps (R7).
        assert_contiguous_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[i] |-> iss_valid[i-1]);
    end

    for (genvar a = 0; a < IW; a++) begin : g_prod
        for (genvar b = a + 1; b < IW; b++) begin : g_cons
            // No consumer beside its producer in one cycle (R8).
            assert_no_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[a] && iss_valid[b] && !iss_fmt[a*2+1]) |->
                !((iss_src1[b*5 +: 4] == iss_dst[a*5 +: 4]) && !iss_fmt[b*2+1]) &&
                !((iss_src2[b*5 +: 4] == iss_dst[a*5 +: 4]) && (iss_fmt[b*2 +: 2] == 2'b00)));
        end
    end

endmodule

bind decode_issue_queue dq_checker #(.IW(IW), .WB_N(WB_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .wb_valid  (wb_valid),
    .iss_valid (iss_valid),
    .iss_fmt   (iss_fmt),
    .iss_dst   (iss_dst),
    .iss_src1  (iss_src1),
    .iss_src2  (iss_src2)
);

// File: tb/decode_issue_queue_tb.sv
`timescale 1ns/1ps
// Bench decode_issue_queue_tb
// Directed sweeps over a 4-deep, 2-wide configuration.
module decode_issue_queue_tb;

    localparam int DEPTH = 4;
    localparam int IW    = 2;
    localparam int WB_N  = 2;
    localparam int ID_W  = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [31:0]          in_word = '0;
    logic [ID_W-1:0]      in_id = '0;
    logic                 q_full;
    logic [WB_N-1:0]      wb_valid = '0;
    logic [WB_N*4-1:0]    wb_reg = '0;
    logic [IW-1:0]        iss_valid;
    logic [IW*ID_W-1:0]   iss_id;
    logic [IW*2-1:0]      iss_fmt;
    logic [IW*4-1:0]      iss_op;
    logic [IW*5-1:0]      iss_dst;
    logic [IW*5-1:0]      iss_src1;
    logic [IW*5-1:0]      iss_src2;
    logic [IW*16-1:0]     iss_imm;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    decode_issue_queue #(.DEPTH(DEPTH), .IW(IW), .WB_N(WB_N), .ID_W(ID_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_id(in_id), .q_full(q_full),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .iss_valid(iss_valid),
        .iss_id(iss_id), .iss_fmt(iss_fmt), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_imm(iss_imm)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    function automatic logic [31:0] rword(input logic [3:0] op, input logic [4:0] d,
                                          input logic [4:0] s1, input logic [4:0] s2,
                                          input logic [10:0] junk);
        return {2'b00, op, d, s1, s2, junk};
    endfunction

    function automatic logic [31:0] iword(input logic [3:0] op, input logic [4:0] d,
                                          input logic [4:0] s1, input logic [15:0] imm);
        return {2'b01, op, d, s1, imm};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        wb_valid = '0;
        #1;
    endtask

    task automatic push(input logic [31:0] w, input logic [7:0] id);
        in_valid = 1'b1;
        in_word  = w;
        in_id    = id;
        @(negedge clk);
        in_valid = 1'b0;
        wb_valid = '0;
        #1;
    endtask

    task automatic wb_set(input logic [1:0] v, input logic [3:0] a, input logic [3:0] b);
        wb_valid = v;
        wb_reg   = {b, a};
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        wb_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset();
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 no issue after reset", iss_valid, 0);
        chk("R11 not full after reset", q_full, 0);

        // R2 register format fields with junk in the low bits
        push(rword(4'hA, 5'd19, 5'd1, 5'd2, 11'h7FF), 8'd10);
        chk("R2 issue", iss_valid, 2'b01);
        chk("R2 id", iss_id[7:0], 10);
        chk("R2 fmt", iss_fmt[1:0], 0);
        chk("R2 op", iss_op[3:0], 4'hA);
        chk("R2 dst", iss_dst[4:0], 19);
        chk("R2 src1", iss_src1[4:0], 1);
        chk("R2 src2", iss_src2[4:0], 2);
        chk("R2 imm", iss_imm[15:0], 0);

        // R3 immediate format fields; r3 is pending from the word above
        push(iword(4'h5, 5'd6, 5'd7, 16'hBEEF), 8'd11);
        chk("R3 issue", iss_valid, 2'b01);
        chk("R3 fmt", iss_fmt[1:0], 1);
        chk("R3 op", iss_op[3:0], 5);
        chk("R3 dst", iss_dst[4:0], 6);
        chk("R3 src1", iss_src1[4:0], 7);
        chk("R3 src2", iss_src2[4:0], 0);
        chk("R3 imm", iss_imm[15:0], 16'hBEEF);
        push(iword(4'h1, 5'd0, 5'd0, 16'h1800), 8'd12);
        chk("R3 bits 15:11 name pending r3 yet no wait", iss_valid, 2'b01);

        // R4 pass-through formats wait on nothing and reserve nothing
        push({2'b10, 4'h3, 5'd12, 5'd3, 16'h0123}, 8'd13);
        chk("R4 jump format issues at once", iss_valid, 2'b01);
        chk("R4 fmt", iss_fmt[1:0], 2);
        chk("R4 imm", iss_imm[15:0], 16'h0123);
        push({2'b11, 4'h3, 5'd13, 5'd6, 16'h0000}, 8'd14);
        chk("R4 prompt format issues at once", iss_valid, 2'b01);
        push(iword(4'h0, 5'd1, 5'd12, 16'h0), 8'd15);
        chk("R4 reader of pass-through dst not delayed", iss_valid, 2'b01);

        // R5 sweep over every register and both source positions
        for (int r = 0; r < 16; r++) begin
            for (int pos = 0; pos < 2; pos++) begin
                logic [4:0] sreg;
                logic [3:0] cdst;
                do_reset();
                sreg = {pos[0] ^ r[0], r[3:0]};
                push(iword(4'h2, {1'b0, r[3:0]}, 5'd0, 16'h1), 8'd1);
                chk("R5 producer issues", iss_valid, 2'b01);
                cdst = (r == 14) ? 4'd15 : 4'd14;
                if (pos == 0)
                    push(iword(4'h3, {1'b0, cdst}, sreg, 16'h0), 8'd2);
                else
                    push(rword(4'h3, {1'b0, cdst}, {1'b0, cdst ^ 4'd1}, sreg, 11'h0), 8'd2);
                chk("R5 reader waits", iss_valid, 2'b00);
                step();
                step();
                chk("R5 reader still waits", iss_valid, 2'b00);
                wb_set(2'b01, r[3:0], 4'd0);
                chk("R5 not during broadcast", iss_valid, 2'b00);
                step();
                chk("R5 reader issues after broadcast", iss_valid, 2'b01);
                chk("R5 reader id", iss_id[7:0], 2);
            end
        end

        // R6, R7, R11 blocked head, full queue, dropped word, paired issue
        do_reset();
        push(iword(0, 5'd5, 5'd0, 16'h0), 8'd1);
        push(rword(0, 5'd6, 5'd5, 5'd0, 11'h0), 8'd2);
        push(iword(0, 5'd7, 5'd0, 16'h1), 8'd3);
        push(iword(0, 5'd8, 5'd0, 16'h1), 8'd4);
        push(iword(0, 5'd9, 5'd0, 16'h1), 8'd5);
        chk("R6 ready younger entries held", iss_valid, 2'b00);
        chk("R11 in_ready low when full", in_ready, 0);
        chk("R11 q_full high", q_full, 1);
        push(iword(0, 5'd10, 5'd0, 16'h0), 8'd99);
        chk("R6 still held", iss_valid, 2'b00);
        wb_set(2'b01, 4'd5, 4'd0);
        step();
        chk("R7 two issue", iss_valid, 2'b11);
        chk("R7 port0 oldest", iss_id[7:0], 2);
        chk("R7 port1 next", iss_id[15:8], 3);
        step();
        chk("R7 second pair", iss_valid, 2'b11);
        chk("R7 second pair ids", iss_id, {8'd5, 8'd4});
        chk("R11 ready after drain", in_ready, 1);
        step();
        chk("R11 word offered while full never issues", iss_valid, 2'b00);

        // R8 producer and consumer not together
        do_reset();
        push(iword(0, 5'd5, 5'd0, 16'h0), 8'd1);
        push(rword(0, 5'd6, 5'd5, 5'd0, 11'h0), 8'd2);
        push(iword(0, 5'd7, 5'd0, 16'h0), 8'd3);
        push(iword(0, 5'd8, 5'd7, 16'h0), 8'd4);
        wb_set(2'b01, 4'd5, 4'd0);
        step();
        chk("R8 head and producer issue", iss_valid, 2'b11);
        chk("R8 ids", iss_id, {8'd3, 8'd2});
        step();
        chk("R8 consumer not beside producer", iss_valid, 2'b00);
        wb_set(2'b01, 4'd7, 4'd0);
        step();
        chk("R8 consumer after writeback", iss_valid, 2'b01);
        chk("R8 consumer id", iss_id[7:0], 4);

        // R9 two writers need two broadcasts, separately
        do_reset();
        push(iword(0, 5'd9, 5'd0, 16'h0), 8'd1);
        push(iword(0, 5'd9, 5'd0, 16'h0), 8'd2);
        push(iword(0, 5'd1, 5'd9, 16'h0), 8'd3);
        chk("R9 waits on both", iss_valid, 2'b00);
        wb_set(2'b01, 4'd9, 4'd0);
        step();
        chk("R9 one broadcast not enough", iss_valid, 2'b00);
        wb_set(2'b01, 4'd9, 4'd0);
        step();
        chk("R9 issues after second", iss_valid, 2'b01);

        // R9 two broadcasts in one cycle
        do_reset();
        push(iword(0, 5'd9, 5'd0, 16'h0), 8'd1);
        push(iword(0, 5'd9, 5'd0, 16'h0), 8'd2);
        push(iword(0, 5'd1, 5'd9, 16'h0), 8'd3);
        wb_set(2'b11, 4'd9, 4'd9);
        step();
        chk("R9 paired broadcasts count twice", iss_valid, 2'b01);
        chk("R9 id", iss_id[7:0], 3);

        // R10 younger writer does not delay older reader
        do_reset();
        push(iword(0, 5'd5, 5'd0, 16'h0), 8'd1);
        push(iword(0, 5'd2, 5'd5, 16'h0), 8'd2);
        push(iword(0, 5'd3, 5'd4, 16'h0), 8'd3);
        push(iword(0, 5'd4, 5'd0, 16'h0), 8'd4);
        wb_set(2'b01, 4'd5, 4'd0);
        step();
        chk("R10 older reader issues", iss_valid, 2'b11);
        chk("R10 ids", iss_id, {8'd3, 8'd2});
        step();
        chk("R10 writer follows", iss_valid, 2'b01);
        chk("R10 writer id", iss_id[7:0], 4);

        // R1 reset mid-flight clears pending writers
        do_reset();
        push(iword(0, 5'd5, 5'd0, 16'h0), 8'd1);
        push(iword(0, 5'd2, 5'd5, 16'h0), 8'd2);
        do_reset();
        chk("R1 empty after reset", iss_valid, 2'b00);
        chk("R1 ready after reset", in_ready, 1);
        push(iword(0, 5'd2, 5'd5, 16'h0), 8'd3);
        chk("R1 reader of cleared register issues", iss_valid, 2'b01);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule